// File: doc/BRIEF.md
# Hot-Plug Interrupt Locator Aggregator

This block gathers the interrupt sources of a hot-plug slot controller into a single locator word and one interrupt request. Each slot keeps a sticky set of five event flags (card presence change, isolated power fault, attention button, retention latch movement, connected power fault). It also keeps a seven-bit disable mask, whose upper two bits gate only system-error reporting. A slot raises its locator bit when any of its events is pending and not masked. A global control word holds four disable bits and two sticky detection flags: command completed and arbiter error. A completed command raises locator bit 0 unless command interrupts are disabled.

The locator and the aggregate level are registered. The request leaves the block in one of two forms. In line mode the level drives a level-sensitive interrupt line. In message mode a one-cycle pulse marks every change of the aggregate level. A two-state notification machine remembers the last level it reported: NOTE_LOW and NOTE_HIGH. Its transitions are *raise* (NOTE_LOW to NOTE_HIGH when the level is high), *drop* (NOTE_HIGH to NOTE_LOW when the level is low) and *hold* (level equals the state). The machine follows the level in both modes.

Registers are written through a simple word port. Address 0 selects the global word. Address n+1 selects slot n. In a slot word, bits 4:0 are the event latch (write one to clear) and bits 14:8 are the disable mask (read/write). In the global word, bits 3:0 are read/write: bit 0 interrupt disable, bit 1 error disable, bit 2 command-interrupt disable, bit 3 arbiter-error disable. Bit 16 (command detected) and bit 17 (arbiter detected) are write one to clear.

Top module: `hpl_locator_agg`

## Requirements
- R1: A high bit on a slot's event input sets the matching latch bit in the same edge, and it stays set. If the same bit is set and written with one for clearing in the same cycle, it ends set.
- R2: Writing a one to bit i (i in 4:0) of slot word n+1 clears latch bit i of slot n. Writing a zero leaves that bit unchanged.
- R3: Bits 14:8 of a slot word load the disable mask, which resets to 0x7F. Locator bit n+1 is set when slot n has a latch bit whose mask bit (same position, 4:0) is clear. Mask bits 5 and 6 do not affect the locator.
- R4: Locator bit 0 is set when command-detected (global bit 16) is set and command-interrupt disable (global bit 2) is clear.
- R5: The level is high when global bit 0 is clear and the locator is non-zero. The locator and the level reflect a write or event sampled at edge k from edge k+1.
- R6: Global bits 3:0 reset to 1 and load from a write. Bits 16 and 17 reset to 0, are set by the command-done and arbiter-error inputs, and are cleared by writing one.
- R7: With message mode on, the pulse output is high for one cycle whenever the level differs from the last reported level, both rising and falling. The reported level tracks the level in both modes, so turning message mode on while the level is already high emits no pulse.
- R8: In line mode the interrupt line equals the level. In message mode the line is low.
- R9: The line and the pulse change at the edge after the level changes, which is edge k+2 for a cause sampled at edge k.
- R10: After reset the locator, level, line, pulse and all event latches are zero.
- R11: A write to an address above N_SLOTS changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Word address: 0 global, n+1 slot n |
| wr_data_i | input | 32 | Write data |
| slot_evt_i | input | N_SLOTS*5 | Event set pulses, slot n at [5n+4:5n] |
| cmd_done_i | input | 1 | Command completed, sets bit 16 |
| arb_err_i | input | 1 | Arbiter error, sets bit 17 |
| msg_en_i | input | 1 | 1 selects message-pulse delivery |
| locator_o | output | N_SLOTS+1 | Registered locator word |
| level_o | output | 1 | Registered aggregate level |
| irq_line_o | output | 1 | Level interrupt line |
| msg_pulse_o | output | 1 | One-cycle notification pulse |
| ctrl_o | output | 4 | Global disable bits 3:0 |
| cmd_det_o | output | 1 | Command-detected flag |
| arb_det_o | output | 1 | Arbiter-detected flag |
| evt_latch_o | output | N_SLOTS*5 | Event latches, slot n at [5n+4:5n] |
| dis_mask_o | output | N_SLOTS*7 | Disable masks, slot n at [7n+6:7n] |

## Verification
The assertions check the following on every cycle: sticky event setting and write-one clearing of latches, that a set global interrupt disable forces the level low, and that the level otherwise follows a non-zero locator. They also check that command-interrupt disable blanks locator bit 0, that out-of-range writes leave the masks stable, that line mode never pulses and that message mode keeps the line low. Only the bench scenarios can show the exact sparse locator values and the two-edge latency to the line and the pulse. The same holds for falling-edge notifications, the absence of a pulse when message mode is turned on over a high level, and set-over-clear priority on a shared cycle.

// File: rtl/hpl_pkg.sv
package hpl_pkg;
    localparam int EVT_W         = 5;
    localparam int DIS_W         = 7;
    localparam int CTRL_W        = 4;
    localparam int DATA_W        = 32;
    localparam int SLOT_DIS_LSB  = 8;
    localparam int G_INT_DIS     = 0;
    localparam int G_CMD_INT_DIS = 2;
    localparam int G_CMD_DET     = 16;
    localparam int G_ARB_DET     = 17;

    typedef enum logic {
        NOTE_LOW  = 1'b0,
        NOTE_HIGH = 1'b1
    } note_state_e;
endpackage

// File: rtl/hpl_slot_regs.sv
module hpl_slot_regs
    import hpl_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_hit_i,
    input  logic [EVT_W-1:0] clr_i,
    input  logic [DIS_W-1:0] dis_wr_i,
    input  logic [EVT_W-1:0] evt_set_i,
    output logic [EVT_W-1:0] latch_o,
    output logic [DIS_W-1:0] dis_o,
    output logic             pend_o
);
    logic [EVT_W-1:0] latch_q;
    logic [DIS_W-1:0] dis_q;
    logic [EVT_W-1:0] clr_mask;

    assign clr_mask = wr_hit_i ? clr_i : '0;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            latch_q <= '0;
            dis_q   <= '1;
        end else begin
            latch_q <= (latch_q & ~clr_mask) | evt_set_i;
            if (wr_hit_i) begin
                dis_q <= dis_wr_i;
            end
        end
    end

    assign pend_o  = |(latch_q & ~dis_q[EVT_W-1:0]);
    assign latch_o = latch_q;
    assign dis_o   = dis_q;

    p_evt_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|evt_set_i) |=> ((latch_q & $past(evt_set_i)) == $past(evt_set_i)));

    p_w1c_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_hit_i |=> ((latch_q & $past(clr_i & ~evt_set_i)) == '0));
endmodule

// File: rtl/hpl_global_reg.sv
module hpl_global_reg
    import hpl_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_hit_i,
    input  logic [CTRL_W-1:0] ctrl_wr_i,
    input  logic              cmd_clr_i,
    input  logic              arb_clr_i,
    input  logic              cmd_done_i,
    input  logic              arb_err_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              cmd_det_o,
    output logic              arb_det_o
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              cmd_q;
    logic              arb_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctrl_q <= '1;
            cmd_q  <= 1'b0;
            arb_q  <= 1'b0;
        end else begin
            if (wr_hit_i) begin
                ctrl_q <= ctrl_wr_i;
            end
            cmd_q <= (cmd_q & ~(wr_hit_i & cmd_clr_i)) | cmd_done_i;
            arb_q <= (arb_q & ~(wr_hit_i & arb_clr_i)) | arb_err_i;
        end
    end

    assign ctrl_o    = ctrl_q;
    assign cmd_det_o = cmd_q;
    assign arb_det_o = arb_q;

    p_cmd_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_done_i |=> cmd_det_o);

    p_ctrl_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_hit_i |=> (ctrl_o == $past(ctrl_wr_i)));
endmodule

// File: rtl/hpl_notify_fsm.sv
module hpl_notify_fsm
    import hpl_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    input  logic msg_en_i,
    output logic pulse_o,
    output logic line_o
);
    note_state_e state_q, state_d;
    logic        differs;
    logic        pulse_q;
    logic        line_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NOTE_LOW:  if (level_i)  state_d = NOTE_HIGH;
            NOTE_HIGH: if (!level_i) state_d = NOTE_LOW;
            default:   state_d = NOTE_LOW;
        endcase
    end

    assign differs = (state_q == NOTE_HIGH) != level_i;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= NOTE_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pulse_q <= 1'b0;
            line_q  <= 1'b0;
        end else begin
            pulse_q <= msg_en_i & differs;
            line_q  <= level_i & ~msg_en_i;
        end
    end

    assign pulse_o = pulse_q;
    assign line_o  = line_q;

    p_no_pulse_line_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !msg_en_i |=> !pulse_o);

    p_line_quiet_msg_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        msg_en_i |=> !line_o);
endmodule

// File: rtl/hpl_locator_agg.sv
module hpl_locator_agg
    import hpl_pkg::*;
#(
    parameter int N_SLOTS = 8,
    localparam int ADDR_W = $clog2(N_SLOTS + 2),
    localparam int LOC_W  = N_SLOTS + 1
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        wr_addr_i,
    input  logic [DATA_W-1:0]        wr_data_i,
    input  logic [N_SLOTS*EVT_W-1:0] slot_evt_i,
    input  logic                     cmd_done_i,
    input  logic                     arb_err_i,
    input  logic                     msg_en_i,
    output logic [LOC_W-1:0]         locator_o,
    output logic                     level_o,
    output logic                     irq_line_o,
    output logic                     msg_pulse_o,
    output logic [CTRL_W-1:0]        ctrl_o,
    output logic                     cmd_det_o,
    output logic                     arb_det_o,
    output logic [N_SLOTS*EVT_W-1:0] evt_latch_o,
    output logic [N_SLOTS*DIS_W-1:0] dis_mask_o
);
    logic [N_SLOTS-1:0]  pend;
    logic [CTRL_W-1:0]   ctrl;
    logic                cmd_det;
    logic                glob_hit;
    logic [LOC_W-1:0]    locator_d, locator_q;
    logic                level_d, level_q;
    logic                unused_wr_bits;

    assign unused_wr_bits = ^{wr_data_i[DATA_W-1:G_ARB_DET+1],
                              wr_data_i[SLOT_DIS_LSB-1:EVT_W],
                              wr_data_i[G_CMD_DET-1:SLOT_DIS_LSB+DIS_W]};

    assign glob_hit = wr_en_i && (wr_addr_i == '0);

    hpl_global_reg u_glob (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_hit_i   (glob_hit),
        .ctrl_wr_i  (wr_data_i[CTRL_W-1:0]),
        .cmd_clr_i  (wr_data_i[G_CMD_DET]),
        .arb_clr_i  (wr_data_i[G_ARB_DET]),
        .cmd_done_i (cmd_done_i),
        .arb_err_i  (arb_err_i),
        .ctrl_o     (ctrl),
        .cmd_det_o  (cmd_det),
        .arb_det_o  (arb_det_o)
    );

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        logic slot_hit;
        assign slot_hit = wr_en_i && (wr_addr_i == ADDR_W'(s + 1));
        hpl_slot_regs u_slot (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .wr_hit_i  (slot_hit),
            .clr_i     (wr_data_i[EVT_W-1:0]),
            .dis_wr_i  (wr_data_i[SLOT_DIS_LSB +: DIS_W]),
            .evt_set_i (slot_evt_i[s*EVT_W +: EVT_W]),
            .latch_o   (evt_latch_o[s*EVT_W +: EVT_W]),
            .dis_o     (dis_mask_o[s*DIS_W +: DIS_W]),
            .pend_o    (pend[s])
        );
    end

    assign locator_d = {pend, cmd_det & ~ctrl[G_CMD_INT_DIS]};
    assign level_d   = ~ctrl[G_INT_DIS] & (|locator_d);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            locator_q <= '0;
            level_q   <= 1'b0;
        end else begin
            locator_q <= locator_d;
            level_q   <= level_d;
        end
    end

    hpl_notify_fsm u_note (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .level_i  (level_q),
        .msg_en_i (msg_en_i),
        .pulse_o  (msg_pulse_o),
        .line_o   (irq_line_o)
    );

    assign locator_o = locator_q;
    assign level_o   = level_q;
    assign ctrl_o    = ctrl;
    assign cmd_det_o = cmd_det;

    p_level_masked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(ctrl[G_INT_DIS]) |-> !level_q);

    p_level_follows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(ctrl[G_INT_DIS]) |-> (level_q == (locator_q != '0)));

    p_cmd_bit_blank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(ctrl[G_CMD_INT_DIS]) |-> !locator_q[0]);

    p_far_write_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && (wr_addr_i > ADDR_W'(N_SLOTS))) |=> $stable(dis_mask_o));
endmodule

// File: tb/hpl_locator_agg_bench.sv
module hpl_locator_agg_bench;
    localparam int NS = 8;
    localparam int AW = $clog2(NS + 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [NS*5-1:0] slot_evt = '0;
    logic          cmd_done = 1'b0;
    logic          arb_err = 1'b0;
    logic          msg_en = 1'b0;
    logic [NS:0]   locator;
    logic          level, line, pulse, cmd_det, arb_det;
    logic [3:0]    ctrl;
    logic [NS*5-1:0] latch;
    logic [NS*7-1:0] dis;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    hpl_locator_agg #(.N_SLOTS(NS)) u_hpl_locator_agg (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .slot_evt_i(slot_evt), .cmd_done_i(cmd_done),
        .arb_err_i(arb_err), .msg_en_i(msg_en), .locator_o(locator),
        .level_o(level), .irq_line_o(line), .msg_pulse_o(pulse),
        .ctrl_o(ctrl), .cmd_det_o(cmd_det), .arb_det_o(arb_det),
        .evt_latch_o(latch), .dis_mask_o(dis)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(int addr, logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = data;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ev(int slot, logic [4:0] bits);
        @(negedge clk);
        slot_evt[slot*5 +: 5] = bits;
        @(posedge clk);
        @(negedge clk);
        slot_evt = '0;
    endtask

    task automatic t_reset();
        chk("R10 locator", 32'(locator), 0);
        chk("R10 level", 32'(level), 0);
        chk("R10 line", 32'(line), 0);
        chk("R10 pulse", 32'(pulse), 0);
        chk("R10 latches", 32'(latch), 0);
        chk("R6 ctrl reset", 32'(ctrl), 32'hF);
        chk("R6 flags reset", 32'({cmd_det, arb_det}), 0);
        chk("R3 mask reset slot2", 32'(dis[14 +: 7]), 32'h7F);
        chk("R3 mask reset slot7", 32'(dis[49 +: 7]), 32'h7F);
    endtask

    task automatic t_masked_event();
        ev(2, 5'h01);
        chk("R1 latch set", 32'(latch[10 +: 5]), 32'h01);
        step();
        chk("R3 masked event", 32'(locator), 0);
    endtask

    task automatic t_unmask();
        wr(3, 32'h7E00);
        chk("R2 zero write keeps latch", 32'(latch[10 +: 5]), 32'h01);
        chk("R3 mask loaded", 32'(dis[14 +: 7]), 32'h7E);
        step();
        chk("R3 locator bit3", 32'(locator), 32'h008);
        chk("R5 level held by disable", 32'(level), 0);
    endtask

    task automatic t_line_mode();
        wr(0, 32'h0E);
        chk("R6 ctrl written", 32'(ctrl), 32'hE);
        step();
        chk("R5 level high", 32'(level), 1);
        chk("R9 line not yet", 32'(line), 0);
        step();
        chk("R8 line follows level", 32'(line), 1);
        chk("R7 no pulse in line mode", 32'(pulse), 0);
    endtask

    task automatic t_serr_bits();
        wr(3, 32'h1E00);
        step();
        chk("R3 upper mask bits ignored", 32'(locator), 32'h008);
        wr(3, 32'h7E00);
    endtask

    task automatic t_w1c();
        wr(3, 32'h7E01);
        chk("R2 latch cleared", 32'(latch[10 +: 5]), 0);
        step();
        chk("R2 locator cleared", 32'(locator), 0);
        step();
        chk("R8 line dropped", 32'(line), 0);
    endtask

    task automatic t_set_wins();
        @(negedge clk);
        slot_evt[10 +: 5] = 5'h01;
        wr_en = 1'b1; wr_addr = AW'(3); wr_data = 32'h7E01;
        @(posedge clk);
        @(negedge clk);
        slot_evt = '0; wr_en = 1'b0;
        chk("R1 set beats clear", 32'(latch[10 +: 5]), 32'h01);
        step();
        chk("R1 locator after tie", 32'(locator), 32'h008);
        wr(3, 32'h7E01);
        step();
        step();
    endtask

    task automatic t_command();
        @(negedge clk);
        cmd_done = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_done = 1'b0;
        chk("R6 cmd flag set", 32'(cmd_det), 1);
        step();
        chk("R4 cmd bit blanked", 32'(locator), 0);
        wr(0, 32'h0A);
        step();
        chk("R4 cmd bit set", 32'(locator), 32'h001);
        chk("R5 level from cmd", 32'(level), 1);
        wr(0, 32'h1000A);
        chk("R6 cmd flag w1c", 32'(cmd_det), 0);
        step();
        chk("R4 cmd bit gone", 32'(locator), 0);
        @(negedge clk);
        arb_err = 1'b1;
        @(posedge clk);
        @(negedge clk);
        arb_err = 1'b0;
        chk("R6 arb flag set", 32'(arb_det), 1);
        wr(0, 32'h2000A);
        chk("R6 arb flag w1c", 32'(arb_det), 0);
        step();
    endtask

    task automatic t_msg_mode();
        @(negedge clk);
        msg_en = 1'b1;
        step();
        step();
        ev(2, 5'h01);
        step();
        chk("R9 pulse not yet", 32'(pulse), 0);
        step();
        chk("R7 rising pulse", 32'(pulse), 1);
        chk("R8 line low in msg mode", 32'(line), 0);
        step();
        chk("R7 pulse one cycle", 32'(pulse), 0);
        wr(3, 32'h7E01);
        step();
        step();
        chk("R7 falling pulse", 32'(pulse), 1);
        step();
        chk("R7 falling pulse ends", 32'(pulse), 0);
    endtask

    task automatic t_switch_mode();
        @(negedge clk);
        msg_en = 1'b0;
        ev(2, 5'h01);
        step();
        step();
        chk("R8 line high", 32'(line), 1);
        msg_en = 1'b1;
        step();
        chk("R7 no pulse on mode switch", 32'(pulse), 0);
        chk("R8 line off in msg mode", 32'(line), 0);
        step();
        chk("R7 still no pulse", 32'(pulse), 0);
        msg_en = 1'b0;
    endtask

    task automatic t_int_disable();
        wr(0, 32'h0B);
        step();
        chk("R5 disable kills level", 32'(level), 0);
        chk("R5 locator kept", 32'(locator), 32'h008);
    endtask

    task automatic t_far_write();
        wr(NS + 1, 32'hFFFF_FFFF);
        chk("R11 mask slot2 kept", 32'(dis[14 +: 7]), 32'h7E);
        chk("R11 mask slot0 kept", 32'(dis[0 +: 7]), 32'h7F);
        chk("R11 latch kept", 32'(latch[10 +: 5]), 32'h01);
        chk("R11 ctrl kept", 32'(ctrl), 32'hB);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_masked_event();
        t_unmask();
        t_line_mode();
        t_serr_bits();
        t_w1c();
        t_set_wins();
        t_command();
        t_msg_mode();
        t_switch_mode();
        t_int_disable();
        t_far_write();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule